// File: doc/BRIEF.md
# Serial Segment-Latch Slave with Readback

This block receives segment data for a four-way multiplexed display over a two-wire bus that uses I2C-style framing. The clock line is an input. The data line is open-drain: the block samples the line and, when it has to pull the line low, raises a drive-low enable. A controller opens a transfer with a start condition and then sends an address byte. The upper seven bits of that byte select the device, and its lowest bit sets the direction. Each byte on the bus is followed by a ninth clock. In write direction the block pulls the line low on that ninth clock to acknowledge. In read direction it leaves the line released on that clock.

Write data enters a 128-bit shift register, one byte at a time. A separate 128-bit display latch feeds the segment drivers. The enable input chooses how the latch is loaded. With enable held high, the latch loads automatically each time 128 data bits have arrived. With enable held low, it loads on a rising edge of enable that occurs while the bus clock is high.

In read direction the block sends back the contents of the shift register, oldest byte first, and leaves them unchanged. When a transfer continues past a 128-bit boundary without a new start, the rising clock edge that follows that block's last ninth clock is ignored. A controller should end a read at a point where the data line is released.

Top module: `segbus_slave`

## Requirements
- R1: A start condition (data line falls while the clock is high) begins an address phase from any state. The address byte is sampled on rising clock edges, MSB first. The device responds only if bits 7..1 equal 0111111. Bit 0 equal to 0 selects write and bit 0 equal to 1 selects read.
- R2: On an address match, the drive-low enable is raised for the ninth clock. On a mismatch the line is never driven, and all traffic is ignored until the next start.
- R3: In write direction, every 8 data bits (MSB first) are acknowledged by pulling the line low for the following ninth clock. The drive is released on the falling clock edge that ends that ninth clock.
- R4: Each completed byte shifts the register toward the MSB, and the new byte enters bits 7..0. After 16 bytes, the first byte received occupies bits 127..120.
- R5: With enable high, the display output takes the shift register value within 3 system clocks after the last bit of every 16th byte. It does not change before that point.
- R6: With enable low, completing 16 bytes leaves the display unchanged. A rising edge of enable while the bus clock is high copies the shift register to the display. A rising edge of enable while the bus clock is low has no effect.
- R7: After the ninth clock that ends a 128-bit block, the next rising clock edge is ignored, and data resumes on the edge after it.
- R8: In read direction the block sends register bytes starting with bits 127..120, MSB first, pulling the line low for a 0 and releasing it for a 1. It releases the line for the ninth clock of each byte. After 16 bytes and one ignored clock, it starts again at the oldest byte. Reading leaves the register unchanged.
- R9: A stop condition (data line rises while the clock is high) releases the line and ends the transfer. Any partial byte is discarded. Clocked data after a stop is ignored until a start and a matching address are received.
- R10: The drive-low enable changes only while the bus clock is low.
- R11: During and after reset, the display output is all zeros and the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Sampled level of the open-drain data line |
| en_i | input | 1 | Latch mode and strobe input |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |
| disp_o | output | 128 | Display latch contents, bit 127 = first bit received |

## Verification
The assertions check on every cycle that the drive-low enable only moves while the bus clock is low. They also check that a start always enters the address phase and that a stop always releases the line and idles the block. On every ninth clock of an address or write acknowledge they check that the line is driven. Finally, they check that the display latch only changes two clocks after a completed block under enable, or one clock after an enable rise with the clock high. Several behaviours need whole bus scenarios from the bench: the byte order in the shift register, the skipped edge at a block boundary, wrap-around and non-destructive readback, discarding of a partial byte on a stop, and ignored traffic after an address mismatch.

// File: rtl/seglink_pkg.sv
`timescale 1ns/1ps
package seglink_pkg;
  parameter int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RGAP,
    ST_SKIP
  } link_st_e;
endpackage

// File: rtl/seglink_cond.sv
`timescale 1ns/1ps
// Bus edge and start/stop condition detector.
module seglink_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/seglink_fsm.sv
`timescale 1ns/1ps
// Framing sequencer: address, acknowledge, write bytes, read bytes, skip edge.
module seglink_fsm
  import seglink_pkg::*;
#(
  parameter int         SEG_BITS = 128,
  parameter logic [6:0] DEV_ADDR = 7'h3F,
  parameter int         IDX_W    = $clog2(SEG_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 sda_i,
  input  logic                 tx_bit_i,
  output link_st_e             st_o,
  output logic                 commit_o,
  output logic [BYTE_W-1:0]    byte_o,
  output logic                 blk_done_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic                 oe_o
);
  localparam int BYTES  = SEG_BITS / BYTE_W;
  localparam int BCNT_W = $clog2(BYTES);
  localparam int BIT_W  = $clog2(BYTE_W);

  link_st_e            st_q, st_n;
  logic [BIT_W-1:0]    bit_q, bit_n;
  logic [BCNT_W-1:0]   bcnt_q, bcnt_n;
  logic [BYTE_W-2:0]   sr_q, sr_n;
  logic                rw_q, rw_n;
  logic                oe_q, oe_n;
  logic                commit;
  logic                last_bit;
  logic [BYTE_W-1:0]   rx_byte;

  assign rx_byte  = {sr_q, sda_i};
  assign last_bit = (bit_q == BIT_W'(BYTE_W - 1));

  always_comb begin
    st_n   = st_q;
    bit_n  = bit_q;
    bcnt_n = bcnt_q;
    sr_n   = sr_q;
    rw_n   = rw_q;
    oe_n   = oe_q;
    commit = 1'b0;
    if (start_i) begin
      st_n   = ST_ADDR;
      bit_n  = '0;
      bcnt_n = '0;
      oe_n   = 1'b0;
    end else if (stop_i) begin
      st_n  = ST_IDLE;
      bit_n = '0;
      oe_n  = 1'b0;
    end else if (scl_rise_i) begin
      case (st_q)
        ST_ADDR: begin
          sr_n = rx_byte[BYTE_W-2:0];
          if (last_bit) begin
            bit_n = '0;
            if (sr_q == DEV_ADDR) begin
              st_n = ST_AACK;
              rw_n = sda_i;
            end else begin
              st_n = ST_IDLE;
            end
          end else begin
            bit_n = bit_q + BIT_W'(1);
          end
        end
        ST_AACK, ST_SKIP: st_n = rw_q ? ST_RDATA : ST_WDATA;
        ST_WDATA: begin
          sr_n = rx_byte[BYTE_W-2:0];
          if (last_bit) begin
            commit = 1'b1;
            bit_n  = '0;
            bcnt_n = bcnt_q + BCNT_W'(1);
            st_n   = ST_WACK;
          end else begin
            bit_n = bit_q + BIT_W'(1);
          end
        end
        ST_RDATA: begin
          if (last_bit) begin
            bit_n  = '0;
            bcnt_n = bcnt_q + BCNT_W'(1);
            st_n   = ST_RGAP;
          end else begin
            bit_n = bit_q + BIT_W'(1);
          end
        end
        ST_WACK, ST_RGAP: begin
          if (bcnt_q == '0)       st_n = ST_SKIP;
          else if (st_q == ST_WACK) st_n = ST_WDATA;
          else                    st_n = ST_RDATA;
        end
        default: ;
      endcase
    end else if (scl_fall_i) begin
      oe_n = (st_q == ST_AACK) || (st_q == ST_WACK) ||
             ((st_q == ST_RDATA) && !tx_bit_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      bcnt_q <= '0;
      sr_q   <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      bit_q  <= bit_n;
      bcnt_q <= bcnt_n;
      sr_q   <= sr_n;
      rw_q   <= rw_n;
      oe_q   <= oe_n;
    end
  end

  assign st_o       = st_q;
  assign commit_o   = commit;
  assign byte_o     = rx_byte;
  assign blk_done_o = commit && (bcnt_q == BCNT_W'(BYTES - 1));
  assign rd_idx_o   = {bcnt_q, bit_q};
  assign oe_o       = oe_q;
endmodule

// File: rtl/seglink_store.sv
`timescale 1ns/1ps
// Segment shift register, display latch and latch-trigger logic.
module seglink_store
  import seglink_pkg::*;
#(
  parameter int SEG_BITS = 128,
  parameter int IDX_W    = $clog2(SEG_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                blk_done_i,
  input  logic                en_i,
  input  logic                scl_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                tx_bit_o,
  output logic [SEG_BITS-1:0] disp_o
);
  logic [SEG_BITS-1:0] shreg_q, shreg_n;
  logic [SEG_BITS-1:0] disp_q, disp_n;
  logic                pend_q, pend_n;
  logic                en_q;
  logic                strobe;

  assign strobe = en_i & ~en_q & scl_i;
  assign pend_n = blk_done_i & en_i;

  always_comb begin
    shreg_n = shreg_q;
    if (commit_i) shreg_n = {shreg_q[SEG_BITS-BYTE_W-1:0], byte_i};
  end

  always_comb begin
    disp_n = disp_q;
    if (pend_q || strobe) disp_n = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      disp_q  <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      shreg_q <= shreg_n;
      disp_q  <= disp_n;
      pend_q  <= pend_n;
      en_q    <= en_i;
    end
  end

  assign tx_bit_o = shreg_q[IDX_W'(SEG_BITS - 1) - rd_idx_i];
  assign disp_o   = disp_q;
endmodule

// File: rtl/segbus_slave.sv
`timescale 1ns/1ps
module segbus_slave
  import seglink_pkg::*;
#(
  parameter int         SEG_BITS = 128,
  parameter logic [6:0] DEV_ADDR = 7'h3F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                en_i,
  output logic                sda_oe_o,
  output logic [SEG_BITS-1:0] disp_o
);
  localparam int IDX_W = $clog2(SEG_BITS);

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              scl_rise, scl_fall, bus_start, bus_stop;
  link_st_e          st;
  logic              commit, blk_done, tx_bit;
  logic [BYTE_W-1:0] rx_byte;
  logic [IDX_W-1:0]  rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  seglink_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  seglink_fsm #(
    .SEG_BITS(SEG_BITS),
    .DEV_ADDR(DEV_ADDR),
    .IDX_W   (IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .sda_i     (sda_i),
    .tx_bit_i  (tx_bit),
    .st_o      (st),
    .commit_o  (commit),
    .byte_o    (rx_byte),
    .blk_done_o(blk_done),
    .rd_idx_o  (rd_idx),
    .oe_o      (sda_oe_o)
  );

  seglink_store #(
    .SEG_BITS(SEG_BITS),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_s),
    .commit_i  (commit),
    .byte_i    (rx_byte),
    .blk_done_i(blk_done),
    .en_i      (en_i),
    .scl_i     (scl_i),
    .rd_idx_i  (rd_idx),
    .tx_bit_o  (tx_bit),
    .disp_o    (disp_o)
  );
endmodule

// File: rtl/seglink_chk.sv
`timescale 1ns/1ps
module seglink_chk
  import seglink_pkg::*;
#(
  parameter int SEG_BITS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_i,
  input logic                en_i,
  input logic                sda_oe_o,
  input logic [SEG_BITS-1:0] disp_o,
  input link_st_e            st,
  input logic                scl_fall,
  input logic                bus_start,
  input logic                bus_stop,
  input logic                blk_done
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (st == ST_ADDR));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!sda_oe_o && st == ST_IDLE));

  // R2
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK && scl_fall) |=> sda_oe_o);

  // R3
  data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WACK && scl_fall) |=> sda_oe_o);

  // R7
  blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (st == ST_WACK));

  // R5
  latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_o) |-> (($past(blk_done, 2) && $past(en_i, 2)) ||
                          ($past(en_i) && !$past(en_i, 2) && $past(scl_i))));
endmodule

bind segbus_slave seglink_chk #(.SEG_BITS(SEG_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .en_i     (en_i),
  .sda_oe_o (sda_oe_o),
  .disp_o   (disp_o),
  .st       (st),
  .scl_fall (scl_fall),
  .bus_start(bus_start),
  .bus_stop (bus_stop),
  .blk_done (blk_done)
);

// File: tb/segbus_slave_tb.sv
`timescale 1ns/1ps
module segbus_slave_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         scl;
  logic         m_low;
  logic         en;
  logic         oe;
  logic [127:0] disp;
  logic         sda_line;
  logic [127:0] ref_sr;
  logic [127:0] hold;
  int           n_chk = 0;
  int           n_bad = 0;
  int           viol = 0;
  logic         oe_prev = 1'b0;
  logic         scl_prev = 1'b1;

  always #4 clk = ~clk;

  assign sda_line = !(oe | m_low);

  segbus_slave u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .en_i    (en),
    .sda_oe_o(oe),
    .disp_o  (disp)
  );

  // R10 monitor: drive enable may only move while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && (oe !== oe_prev) && scl && scl_prev) viol++;
    oe_prev  <= oe;
    scl_prev <= scl;
  end

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; hw();
    scl = 1'b1;   hw();
    m_low = 1'b1; hw();
    scl = 1'b0;   hw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hw();
    scl = 1'b1;   hw();
    m_low = 1'b0; hw();
  endtask

  task automatic bit_out(input logic b);
    m_low = !b; hw();
    scl = 1'b1; hw();
    scl = 1'b0; hw();
  endtask

  task automatic clk9(output logic v);
    m_low = 1'b0; hw();
    scl = 1'b1;   hw();
    v = sda_line;
    scl = 1'b0;   hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    clk9(v);
    acked = !v;
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic gap);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; hw();
      scl = 1'b1;   hw();
      b[i] = sda_line;
      scl = 1'b0;   hw();
    end
    clk9(gap);
  endtask

  task automatic strobe();
    en = 1'b1; hw();
    en = 1'b0; hw();
  endtask

  // expected register: new byte enters at the bottom (R4)
  function automatic logic [127:0] push(input logic [127:0] r, input logic [7:0] b);
    return {r[119:0], b};
  endfunction

  task automatic wr_bytes(input int n, input bit set_msb2, input string req);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      logic       a;
      b = 8'($urandom);
      if (set_msb2 && k == 2) b[7] = 1'b1;
      send_byte(b, a);
      ref_sr = push(ref_sr, b);
      chk(a, req, {127'd0, a}, 128'd1);
    end
  endtask

  task automatic address(input logic [7:0] a, input logic exp_ack, input string req);
    logic ak;
    bus_start();
    send_byte(a, ak);
    chk(ak == exp_ack, req, {127'd0, ak}, {127'd0, exp_ack});
  endtask

  initial begin
    logic       v;
    logic [7:0] rb;
    logic       g;
    void'($urandom(32'h0005_EED1));
    ref_sr = '0;
    scl = 1'b1; m_low = 1'b0; en = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(disp == '0, "R11 display at reset", disp, '0);
    chk(oe == 1'b0, "R11 line released at reset", {127'd0, oe}, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(disp == '0 && oe == 1'b0, "R11 state after reset", disp, '0);

    // Count-triggered writes across two blocks with skip edge
    address(8'h7E, 1'b1, "R1 R2 write address acknowledged");
    wr_bytes(15, 1'b0, "R3 write byte acknowledged");
    chk(disp == '0, "R5 no latch before 16th byte", disp, '0);
    wr_bytes(1, 1'b0, "R3 write byte acknowledged");
    chk(disp == ref_sr, "R4 R5 latch after 128 bits", disp, ref_sr);
    bit_out(1'b1);  // ignored edge (R7)
    wr_bytes(16, 1'b1, "R3 write byte acknowledged");
    chk(disp == ref_sr, "R7 second block aligned after skip", disp, ref_sr);
    bit_out(1'b0);
    bus_stop();
    chk(oe == 1'b0, "R9 line released after stop", {127'd0, oe}, '0);

    // Readback, oldest byte first, with wrap
    address(8'h7F, 1'b1, "R1 R2 read address acknowledged");
    for (int k = 0; k < 16; k++) begin
      recv_byte(rb, g);
      chk(rb == ref_sr[127 - 8*k -: 8], "R8 read byte", {120'd0, rb}, {120'd0, ref_sr[127 - 8*k -: 8]});
      chk(g == 1'b1, "R8 released on ninth clock", {127'd0, g}, 128'd1);
    end
    clk9(v);
    chk(v == 1'b1, "R8 R7 skip clock released", {127'd0, v}, 128'd1);
    for (int k = 0; k < 2; k++) begin
      recv_byte(rb, g);
      chk(rb == ref_sr[127 - 8*k -: 8], "R8 read wraps to oldest", {120'd0, rb}, {120'd0, ref_sr[127 - 8*k -: 8]});
    end
    bus_stop();
    chk(disp == ref_sr, "R8 read leaves display", disp, ref_sr);

    // Mismatched address: no acknowledge, traffic ignored
    en = 1'b0;
    address(8'hFE, 1'b0, "R1 R2 mismatched address not acknowledged");
    send_byte(8'h00, v);
    chk(v == 1'b0, "R2 no acknowledge after mismatch", {127'd0, v}, '0);
    bus_stop();
    strobe();
    chk(disp == ref_sr, "R2 R8 register intact after read and mismatch", disp, ref_sr);

    // Strobe mode: count suppressed, low-clock strobe ignored
    hold = disp;
    address(8'h7E, 1'b1, "R2 write address acknowledged");
    wr_bytes(8, 1'b0, "R3 write byte acknowledged");
    strobe();
    chk(disp == hold, "R6 strobe with clock low ignored", disp, hold);
    wr_bytes(8, 1'b0, "R3 write byte acknowledged");
    chk(disp == hold, "R6 count latch suppressed", disp, hold);
    bit_out(1'b0);
    bus_stop();
    strobe();
    chk(disp == ref_sr, "R6 strobe with clock high latches", disp, ref_sr);

    // Stop abort with partial byte, then ignored traffic
    en = 1'b1; hw();
    address(8'h7E, 1'b1, "R2 write address acknowledged");
    wr_bytes(5, 1'b0, "R3 write byte acknowledged");
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_stop();
    chk(oe == 1'b0, "R9 stop mid-byte releases line", {127'd0, oe}, '0);
    scl = 1'b0; hw();
    send_byte(8'hA5, v);
    chk(v == 1'b0, "R9 no acknowledge without start", {127'd0, v}, '0);
    address(8'h7E, 1'b1, "R9 restart address acknowledged");
    wr_bytes(16, 1'b0, "R3 write byte acknowledged");
    chk(disp == ref_sr, "R9 partial byte discarded and block restarted", disp, ref_sr);
    bit_out(1'b0);
    bus_stop();

    chk(viol == 0, "R10 drive changed while clock high", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule